// File: doc/BRIEF.md
# Trapezoidal Step Pulse Generator

This block drives one stepper axis with a step pulse train and a direction level. A move can run at a fixed speed or follow a trapezoid: it leaves at a low speed, climbs one speed unit at a time to a chosen high speed, cruises there, and then falls back to the low speed. Deceleration is triggered by distance: it starts when the number of pulses still to go drops to a ramp-down point. That point is either programmed or taken from the number of pulses spent accelerating.

Software loads eight parameter registers through a byte-wide port. These are the pulse count, the low speed, two high speeds, the acceleration and deceleration rates, the ramp-down point and a rate multiplier. A byte command starts, retargets or stops a move. A mode byte sets the direction and which features are active. Live status outputs give the current speed, a position count, the remaining pulse count and the reason for the last stop.

The output rate is `speed × fclk / (8192 × multiplier)`. A speed value of 4096 with a multiplier of 1 therefore gives one pulse every two clocks.

Top module: `step_profile_gen`

## Requirements
- R1: Parameter writes select a register with `wr_reg` (0 count, 1 low speed, 2 high speed A, 3 high speed B, 4 acceleration rate, 5 deceleration rate, 6 ramp-down point, 7 multiplier) and a byte with `wr_lane` (2 high, 1 middle, 0 low). Lanes 2 and 1 only stage. A lane-0 write commits all three bytes, so a write without lane 0 leaves the register unchanged.
- R2: A command byte whose bits 7:6 are 00, with bit 4 set, bit 3 clear and bit 2 clear, runs at a fixed speed chosen by bits 1:0: 00 and 10 low, 01 high A, 11 high B. `cur_speed` shows that value from the cycle after the command.
- R3: At speed S and multiplier M (with S a power of two), the step period is M·8192/S clocks and `step_out` is high for half of it.
- R4: With mode bit 2 set, `remaining` loads the count at start and falls by one per pulse. Exactly that many pulses are produced, and the move then ends with `remaining` 0 and stop cause bit 3. `step_out` is low whenever `busy` is low.
- R5: With mode bit 5 set, `position` rises by one per pulse for clockwise moves (mode bit 3 = 0) and falls by one for counter-clockwise moves. With bit 5 clear it holds.
- R6: A command with bit 2 set and a high speed selected loads the low speed and steps `cur_speed` by one unit every A clocks toward the high speed, where A is the acceleration rate. It stops exactly at the high speed, and it never changes by more than one unit per cycle while running.
- R7: With the count stop active and mode bit 4 clear, deceleration to the low speed begins once `remaining` is at or below the programmed ramp-down point.
- R8: With mode bit 4 set, the programmed point is ignored. Deceleration begins once `remaining` is at or below the number of pulses emitted while accelerating.
- R9: Command 0x14 during a move decelerates by one unit every D clocks (D the deceleration rate) down to the low speed and keeps running.
- R10: Command 0x1F during a move decelerates to the low speed and then ends the move with stop cause bit 4. Later start commands are ignored until an immediate stop command.
- R11: Command 0x08 stops at once and clears `irq`. Command 0x28 stops at once and sets `irq`. Either one, issued during a move, records stop cause bit 6.
- R12: A start command with bit 5 set makes `irq` rise when that move ends by itself.
- R13: A positive limit during a clockwise move, a negative limit during a counter-clockwise move, or an alarm ends the move at once. The cause bit is 1, 0 or 5 respectively, and only one cause bit is set at a time. A limit on the opposite side has no effect.
- R14: `dir_out` follows the mode direction only while idle. It holds for the whole move, so it is stable before the first pulse.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| wr_en | input | 1 | Parameter byte write strobe |
| wr_reg | input | 3 | Parameter register index |
| wr_lane | input | 2 | Byte lane, 0 commits |
| wr_data | input | 8 | Byte to write |
| cmd_wr | input | 1 | Command byte strobe |
| cmd_data | input | 8 | Command byte |
| mode_wr | input | 1 | Mode byte strobe |
| mode_data | input | 8 | Mode byte (bits 7:6 must be 01) |
| lim_pos | input | 1 | Positive travel limit, active high |
| lim_neg | input | 1 | Negative travel limit, active high |
| alarm_in | input | 1 | Drive alarm, active high |
| step_out | output | 1 | Step pulse |
| dir_out | output | 1 | Direction, 1 = counter-clockwise |
| busy | output | 1 | Move in progress |
| irq | output | 1 | Interrupt level |
| cur_speed | output | 13 | Current speed value |
| position | output | 24 | Position counter |
| remaining | output | 24 | Pulses left in the move |
| stop_cause | output | 7 | Reason for the last stop |

## Verification
The hardest state to reach from the ports is the distance-based ramp-down. It occurs only after a full acceleration has finished and while the pulse count is running out. In automatic mode, the trigger point is an internal count that is never exposed. The bench runs complete ramped moves with short rates and a speed span of a few dozen units. It tracks the pulses seen while the speed is still rising and records `remaining` at the first speed drop. The programmed point is set far away in that run, so honouring it by mistake would show up. The locked state after a decelerating stop is reached by retargeting a running move, and then probing it with start commands before and after the releasing command.

// File: rtl/spg_pkg.sv
package spg_pkg;
    localparam int CNT_W     = 24;
    localparam int SPD_W     = 13;
    localparam int RATE_W    = 14;
    localparam int RDP_W     = 20;
    localparam int MUL_W     = 16;
    localparam int CAUSE_W   = 7;
    localparam int REG_IDX_W = 3;
    localparam int LANE_W    = 2;
    localparam int STAGE_W   = CNT_W - 8;

    // stop cause bit positions
    localparam int CZ_NEG   = 0;
    localparam int CZ_POS   = 1;
    localparam int CZ_ORG   = 2;
    localparam int CZ_COUNT = 3;
    localparam int CZ_RSTOP = 4;
    localparam int CZ_ALARM = 5;
    localparam int CZ_CMD   = 6;

    typedef enum logic [REG_IDX_W-1:0] {
        RG_PRESET, RG_LOW, RG_HIGH_A, RG_HIGH_B,
        RG_ACCEL, RG_DECEL, RG_RDPOINT, RG_MULT
    } reg_idx_e;

    typedef struct packed {
        logic [CNT_W-1:0]  preset;
        logic [SPD_W-1:0]  low;
        logic [SPD_W-1:0]  high_a;
        logic [SPD_W-1:0]  high_b;
        logic [RATE_W-1:0] accel;
        logic [RATE_W-1:0] decel;
        logic [RDP_W-1:0]  rdpoint;
        logic [MUL_W-1:0]  mult;
    } spg_cfg_t;

    typedef struct packed {
        logic       valid;
        logic       irq_req;
        logic       start;
        logic       halt;
        logic       ramped;
        logic [1:0] sel;
    } spg_cmd_t;

    typedef struct packed {
        logic pos_en;
        logic auto_rd;
        logic ccw;
        logic cnt_stop;
    } spg_mode_t;

    typedef enum logic [1:0] {ST_IDLE, ST_RUN, ST_LOCK} spg_state_e;

    function automatic spg_cmd_t decode_cmd(input logic [7:0] b);
        spg_cmd_t c;
        c.valid   = (b[7:6] == 2'b00);
        c.irq_req = b[5];
        c.start   = b[4];
        c.halt    = b[3];
        c.ramped  = b[2];
        c.sel     = b[1:0];
        return c;
    endfunction

    function automatic spg_mode_t decode_mode(input logic [7:0] b);
        spg_mode_t m;
        m.pos_en   = b[5];
        m.auto_rd  = b[4];
        m.ccw      = b[3];
        m.cnt_stop = b[2];
        return m;
    endfunction

    function automatic logic [SPD_W-1:0] pick_speed(input spg_cfg_t cfg, input logic [1:0] sel);
        case (sel)
            2'b01:   return cfg.high_a;
            2'b11:   return cfg.high_b;
            default: return cfg.low;
        endcase
    endfunction
endpackage

// File: rtl/spg_regfile.sv
module spg_regfile
    import spg_pkg::*;
(
    input  logic                 clk,
    input  logic                 rst,
    input  logic                 wr_en,
    input  logic [REG_IDX_W-1:0] wr_reg,
    input  logic [LANE_W-1:0]    wr_lane,
    input  logic [7:0]           wr_data,
    output spg_cfg_t             cfg
);
    logic [STAGE_W-1:0] stage_q;
    logic [CNT_W-1:0]   full_word;

    assign full_word = {stage_q, wr_data};

    always_ff @(posedge clk) begin
        if (rst) begin
            stage_q <= '0;
            cfg     <= '0;
        end else if (wr_en) begin
            case (wr_lane)
                2'd2: stage_q[STAGE_W-1:8] <= wr_data;
                2'd1: stage_q[7:0]         <= wr_data;
                2'd0: begin
                    case (reg_idx_e'(wr_reg))
                        RG_PRESET:  cfg.preset  <= full_word;
                        RG_LOW:     cfg.low     <= full_word[SPD_W-1:0];
                        RG_HIGH_A:  cfg.high_a  <= full_word[SPD_W-1:0];
                        RG_HIGH_B:  cfg.high_b  <= full_word[SPD_W-1:0];
                        RG_ACCEL:   cfg.accel   <= full_word[RATE_W-1:0];
                        RG_DECEL:   cfg.decel   <= full_word[RATE_W-1:0];
                        RG_RDPOINT: cfg.rdpoint <= full_word[RDP_W-1:0];
                        RG_MULT:    cfg.mult    <= full_word[MUL_W-1:0];
                        default:    ;
                    endcase
                end
                default: ;
            endcase
        end
    end
endmodule

// File: rtl/spg_rate_gen.sv
module spg_rate_gen
    import spg_pkg::*;
(
    input  logic             clk,
    input  logic             rst,
    input  logic             run,
    input  logic [SPD_W-1:0] speed,
    input  logic [MUL_W-1:0] mult,
    output logic             step_out,
    output logic             step_evt
);
    logic [MUL_W-1:0] pre_cnt;
    logic [MUL_W-1:0] mult_eff;
    logic [SPD_W-1:0] phase;
    logic [SPD_W:0]   phase_sum;
    logic             tick;

    assign mult_eff  = (mult == '0) ? MUL_W'(1) : mult;
    assign tick      = (pre_cnt >= mult_eff - MUL_W'(1));
    assign phase_sum = {1'b0, phase} + {1'b0, speed};
    assign step_evt  = run & tick & phase_sum[SPD_W];
    assign step_out  = run & phase[SPD_W-1];

    always_ff @(posedge clk) begin
        if (rst || !run) begin
            pre_cnt <= '0;
            phase   <= '0;
        end else if (tick) begin
            pre_cnt <= '0;
            phase   <= phase_sum[SPD_W-1:0];
        end else begin
            pre_cnt <= pre_cnt + MUL_W'(1);
        end
    end
endmodule

// File: rtl/spg_ramp.sv
module spg_ramp
    import spg_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              run,
    input  logic              load,
    input  logic [SPD_W-1:0]  load_val,
    input  logic [SPD_W-1:0]  target,
    input  logic [RATE_W-1:0] accel,
    input  logic [RATE_W-1:0] decel,
    output logic [SPD_W-1:0]  cur_speed
);
    logic [RATE_W-1:0] cnt;
    logic [RATE_W-1:0] rate;
    logic [RATE_W-1:0] rate_eff;
    logic              going_up;

    assign going_up = (target > cur_speed);
    assign rate     = going_up ? accel : decel;
    assign rate_eff = (rate == '0) ? RATE_W'(1) : rate;

    always_ff @(posedge clk) begin
        if (rst) begin
            cur_speed <= '0;
            cnt       <= '0;
        end else if (load) begin
            cur_speed <= load_val;
            cnt       <= '0;
        end else if (!run || cur_speed == target) begin
            cnt <= '0;
        end else if (cnt >= rate_eff - RATE_W'(1)) begin
            cnt       <= '0;
            cur_speed <= going_up ? cur_speed + SPD_W'(1) : cur_speed - SPD_W'(1);
        end else begin
            cnt <= cnt + RATE_W'(1);
        end
    end
endmodule

// File: rtl/step_profile_gen.sv
module step_profile_gen
    import spg_pkg::*;
(
    input  logic                 clk,
    input  logic                 rst,
    input  logic                 wr_en,
    input  logic [REG_IDX_W-1:0] wr_reg,
    input  logic [LANE_W-1:0]    wr_lane,
    input  logic [7:0]           wr_data,
    input  logic                 cmd_wr,
    input  logic [7:0]           cmd_data,
    input  logic                 mode_wr,
    input  logic [7:0]           mode_data,
    input  logic                 lim_pos,
    input  logic                 lim_neg,
    input  logic                 alarm_in,
    output logic                 step_out,
    output logic                 dir_out,
    output logic                 busy,
    output logic                 irq,
    output logic [SPD_W-1:0]     cur_speed,
    output logic [CNT_W-1:0]     position,
    output logic [CNT_W-1:0]     remaining,
    output logic [CAUSE_W-1:0]   stop_cause
);
    spg_cfg_t   cfg;
    spg_cmd_t   cmd;
    spg_mode_t  mode_q;
    spg_state_e state_q;

    logic               dir_q;
    logic [1:0]         sel_q;
    logic               ramped_q;
    logic               descend_q;
    logic               dstop_q;
    logic               irq_on_stop_q;
    logic               irq_q;
    logic [CNT_W-1:0]   accel_cnt_q;
    logic [CNT_W-1:0]   remain_q;
    logic [CNT_W-1:0]   pos_q;
    logic [CAUSE_W-1:0] cause_q;

    logic               run;
    logic               step_evt;
    logic               is_imm, is_dstop, is_start;
    logic               ramp_load;
    logic [SPD_W-1:0]   load_val;
    logic [SPD_W-1:0]   hi_val;
    logic [SPD_W-1:0]   target;
    logic [CNT_W-1:0]   rd_point;
    logic               rd_hit;
    logic               lim_hit;
    logic [CAUSE_W-1:0] lim_cause;
    logic               cnt_end;
    logic               dstop_end;

    spg_regfile u_regs (
        .clk     (clk),
        .rst     (rst),
        .wr_en   (wr_en),
        .wr_reg  (wr_reg),
        .wr_lane (wr_lane),
        .wr_data (wr_data),
        .cfg     (cfg)
    );

    assign run      = (state_q == ST_RUN);
    assign cmd      = decode_cmd(cmd_data);
    assign is_imm   = cmd_wr & cmd.valid & cmd.halt & ~cmd.start;
    assign is_dstop = cmd_wr & cmd.valid & cmd.halt &  cmd.start;
    assign is_start = cmd_wr & cmd.valid & cmd.start & ~cmd.halt;

    assign ramp_load = is_start & (state_q == ST_IDLE);
    assign load_val  = cmd.ramped ? cfg.low : pick_speed(cfg, cmd.sel);
    assign hi_val    = pick_speed(cfg, sel_q);
    assign target    = (ramped_q && descend_q) ? cfg.low : hi_val;

    assign rd_point  = mode_q.auto_rd ? accel_cnt_q : CNT_W'(cfg.rdpoint);
    assign rd_hit    = run & ramped_q & mode_q.cnt_stop & (remain_q <= rd_point);
    assign cnt_end   = run & mode_q.cnt_stop & step_evt & (remain_q == CNT_W'(1));
    assign dstop_end = run & dstop_q & (cur_speed <= cfg.low);

    // one cause only: alarm ranks above the limits
    always_comb begin
        lim_cause = '0;
        lim_hit   = 1'b0;
        if (run) begin
            if (alarm_in) begin
                lim_hit = 1'b1;
                lim_cause[CZ_ALARM] = 1'b1;
            end else if (!dir_q && lim_pos) begin
                lim_hit = 1'b1;
                lim_cause[CZ_POS] = 1'b1;
            end else if (dir_q && lim_neg) begin
                lim_hit = 1'b1;
                lim_cause[CZ_NEG] = 1'b1;
            end
        end
    end

    spg_ramp u_ramp (
        .clk       (clk),
        .rst       (rst),
        .run       (run),
        .load      (ramp_load),
        .load_val  (load_val),
        .target    (target),
        .accel     (cfg.accel),
        .decel     (cfg.decel),
        .cur_speed (cur_speed)
    );

    spg_rate_gen u_rate (
        .clk      (clk),
        .rst      (rst),
        .run      (run),
        .speed    (cur_speed),
        .mult     (cfg.mult),
        .step_out (step_out),
        .step_evt (step_evt)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            state_q       <= ST_IDLE;
            mode_q        <= '0;
            dir_q         <= 1'b0;
            sel_q         <= '0;
            ramped_q      <= 1'b0;
            descend_q     <= 1'b0;
            dstop_q       <= 1'b0;
            irq_on_stop_q <= 1'b0;
            irq_q         <= 1'b0;
            accel_cnt_q   <= '0;
            remain_q      <= '0;
            pos_q         <= '0;
            cause_q       <= '0;
        end else begin
            if (mode_wr && mode_data[7:6] == 2'b01)
                mode_q <= decode_mode(mode_data);
            if (!run)
                dir_q <= mode_q.ccw;

            if (run && step_evt) begin
                if (mode_q.cnt_stop)
                    remain_q <= remain_q - CNT_W'(1);
                if (mode_q.pos_en)
                    pos_q <= dir_q ? pos_q - CNT_W'(1) : pos_q + CNT_W'(1);
                if (ramped_q && !descend_q && cur_speed < hi_val)
                    accel_cnt_q <= accel_cnt_q + CNT_W'(1);
            end

            if (rd_hit)
                descend_q <= 1'b1;

            if (is_imm) begin
                state_q <= ST_IDLE;
                irq_q   <= cmd.irq_req;
                dstop_q <= 1'b0;
                if (run)
                    cause_q <= CAUSE_W'(1) << CZ_CMD;
            end else if (lim_hit) begin
                state_q <= ST_IDLE;
                cause_q <= lim_cause;
                if (irq_on_stop_q) irq_q <= 1'b1;
            end else if (cnt_end) begin
                state_q <= ST_IDLE;
                cause_q <= CAUSE_W'(1) << CZ_COUNT;
                if (irq_on_stop_q) irq_q <= 1'b1;
            end else if (dstop_end) begin
                state_q <= ST_LOCK;
                dstop_q <= 1'b0;
                cause_q <= CAUSE_W'(1) << CZ_RSTOP;
                if (irq_on_stop_q) irq_q <= 1'b1;
            end else if (is_dstop && run) begin
                dstop_q   <= 1'b1;
                descend_q <= 1'b1;
            end else if (is_start) begin
                if (state_q == ST_IDLE) begin
                    state_q       <= ST_RUN;
                    sel_q         <= cmd.sel;
                    ramped_q      <= cmd.ramped;
                    descend_q     <= 1'b0;
                    dstop_q       <= 1'b0;
                    accel_cnt_q   <= '0;
                    remain_q      <= cfg.preset;
                    cause_q       <= '0;
                    irq_on_stop_q <= cmd.irq_req;
                end else if (run) begin
                    sel_q         <= cmd.sel;
                    ramped_q      <= cmd.ramped;
                    descend_q     <= cmd.ramped & ~cmd.sel[0];
                    irq_on_stop_q <= cmd.irq_req;
                end
            end
        end
    end

    assign dir_out    = dir_q;
    assign busy       = run;
    assign irq        = irq_q;
    assign position   = pos_q;
    assign remaining  = remain_q;
    assign stop_cause = cause_q;
endmodule

// File: rtl/spg_checker.sv
module spg_checker
    import spg_pkg::*;
(
    input logic               clk,
    input logic               rst,
    input logic               cmd_wr,
    input logic [7:0]         cmd_data,
    input logic               step_out,
    input logic               dir_out,
    input logic               busy,
    input logic               irq,
    input logic [SPD_W-1:0]   cur_speed,
    input logic [CNT_W-1:0]   remaining,
    input logic [CAUSE_W-1:0] stop_cause
);
    AST_SPEED_STEP: assert property (@(posedge clk) disable iff (rst)
        (busy && $past(busy)) |-> (cur_speed == $past(cur_speed) ||
                                   cur_speed == $past(cur_speed) + SPD_W'(1) ||
                                   cur_speed == $past(cur_speed) - SPD_W'(1))); // R6

    AST_DIR_HELD: assert property (@(posedge clk) disable iff (rst)
        (busy && $past(busy)) |-> $stable(dir_out)); // R14

    AST_DIR_BEFORE_STEP: assert property (@(posedge clk) disable iff (rst)
        $rose(step_out) |-> $stable(dir_out)); // R14

    AST_IDLE_QUIET: assert property (@(posedge clk) disable iff (rst)
        !busy |-> !step_out); // R4

    AST_COUNT_ZERO: assert property (@(posedge clk) disable iff (rst)
        ($fell(busy) && stop_cause[CZ_COUNT]) |-> (remaining == '0)); // R4

    AST_IRQ_CLEAR: assert property (@(posedge clk) disable iff (rst)
        (cmd_wr && cmd_data == 8'h08) |=> !irq); // R11

    AST_ONE_CAUSE: assert property (@(posedge clk) disable iff (rst)
        $onehot0(stop_cause)); // R13
endmodule

bind step_profile_gen spg_checker u_chk (
    .clk        (clk),
    .rst        (rst),
    .cmd_wr     (cmd_wr),
    .cmd_data   (cmd_data),
    .step_out   (step_out),
    .dir_out    (dir_out),
    .busy       (busy),
    .irq        (irq),
    .cur_speed  (cur_speed),
    .remaining  (remaining),
    .stop_cause (stop_cause)
);

// File: tb/step_profile_gen_tb.sv
module step_profile_gen_tb;
    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        wr_en = 1'b0;
    logic [2:0]  wr_reg = '0;
    logic [1:0]  wr_lane = '0;
    logic [7:0]  wr_data = '0;
    logic        cmd_wr = 1'b0;
    logic [7:0]  cmd_data = '0;
    logic        mode_wr = 1'b0;
    logic [7:0]  mode_data = '0;
    logic        lim_pos = 1'b0;
    logic        lim_neg = 1'b0;
    logic        alarm_in = 1'b0;
    logic        step_out, dir_out, busy, irq;
    logic [12:0] cur_speed;
    logic [23:0] position, remaining;
    logic [6:0]  stop_cause;

    int tests = 0;
    int fails = 0;
    bit done = 0;
    int rises = 0;
    int dir_viol = 0;
    int cyc = 0;
    logic prev_step = 0, prev_busy = 0, prev_dir = 0;

    step_profile_gen u_dut (
        .clk(clk), .rst(rst), .wr_en(wr_en), .wr_reg(wr_reg), .wr_lane(wr_lane),
        .wr_data(wr_data), .cmd_wr(cmd_wr), .cmd_data(cmd_data), .mode_wr(mode_wr),
        .mode_data(mode_data), .lim_pos(lim_pos), .lim_neg(lim_neg), .alarm_in(alarm_in),
        .step_out(step_out), .dir_out(dir_out), .busy(busy), .irq(irq),
        .cur_speed(cur_speed), .position(position), .remaining(remaining),
        .stop_cause(stop_cause)
    );

    always #2 clk = ~clk;

    always @(posedge clk) cyc <= cyc + 1;

    always @(negedge clk) begin
        if (step_out && !prev_step) rises <= rises + 1;
        if (busy && prev_busy && dir_out != prev_dir) dir_viol <= dir_viol + 1;
        prev_step <= step_out;
        prev_busy <= busy;
        prev_dir  <= dir_out;
    end

    function automatic int exp_period(int spd, int mul);
        return mul * 8192 / spd;
    endfunction

    task automatic chk(string req, longint act, longint exp);
        tests++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    task automatic tick(int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic put_reg(int idx, int val);
        for (int l = 2; l >= 0; l--) begin
            @(negedge clk);
            wr_en = 1; wr_reg = 3'(idx); wr_lane = 2'(l); wr_data = 8'(val >> (8 * l));
        end
        @(negedge clk);
        wr_en = 0;
    endtask

    task automatic put_cmd(int b);
        @(negedge clk);
        cmd_wr = 1; cmd_data = 8'(b);
        @(negedge clk);
        cmd_wr = 0;
    endtask

    task automatic put_mode(int b);
        @(negedge clk);
        mode_wr = 1; mode_data = 8'(b);
        @(negedge clk);
        mode_wr = 0;
    endtask

    task automatic wait_idle(int lim);
        for (int i = 0; i < lim && busy; i++) @(negedge clk);
    endtask

    task automatic wait_step(logic v, int lim);
        for (int i = 0; i < lim && step_out !== v; i++) @(negedge clk);
    endtask

    // watches speed changes; returns interval between first two changes and extremes
    task automatic watch_speed(int cycles, output int intv, output int maxv, output int minv);
        int t0, t1, n;
        logic [12:0] last;
        n = 0; t0 = 0; t1 = 0;
        last = cur_speed; maxv = cur_speed; minv = cur_speed;
        for (int i = 0; i < cycles; i++) begin
            @(negedge clk);
            if (cur_speed != last) begin
                if (n == 0) t0 = cyc;
                if (n == 1) t1 = cyc;
                n++;
            end
            if (int'(cur_speed) > maxv) maxv = cur_speed;
            if (int'(cur_speed) < minv) minv = cur_speed;
            last = cur_speed;
        end
        intv = (n >= 2) ? (t1 - t0) : -1;
    endtask

    // runs a ramped counted move; reports remaining at first speed drop and pulses while rising
    task automatic ramp_move(int hi, output int rem_at, output int acc_pulses, output int pulses);
        logic [12:0] last;
        logic pst;
        bit dropped;
        rem_at = -1; acc_pulses = 0; pulses = 0; dropped = 0;
        put_cmd(8'h15);
        last = cur_speed; pst = step_out;
        for (int i = 0; i < 20000 && busy; i++) begin
            @(negedge clk);
            if (!step_out && pst) begin
                pulses++;
                if (!dropped && int'(cur_speed) < hi) acc_pulses++;
            end
            if (!dropped && cur_speed < last) begin
                dropped = 1;
                rem_at = remaining;
            end
            last = cur_speed;
            pst = step_out;
        end
    endtask

    initial begin
        repeat (50000) @(posedge clk);
        if (!done) begin
            fails++;
            $display("FAIL watchdog all-requirements actual=timeout expected=completion");
            $display("[TB] %0d tests run, %0d failed", tests, fails);
            $finish;
        end
    end

    initial begin
        int r0, p0, intv, mx, mn, t1, t2, t3, rem_at, accp, pulses;
        void'($urandom(32'h5EED_0017));
        tick(4);
        rst = 0;
        tick(2);
        // reset state
        chk("R4 reset busy", busy, 0);
        chk("R4 reset step", step_out, 0);
        chk("R11 reset irq", irq, 0);
        chk("R6 reset speed", cur_speed, 0);
        chk("R5 reset position", position, 0);
        chk("R13 reset cause", stop_cause, 0);

        // R1 / R4 / R5: counted constant move, with an uncommitted partial write
        put_reg(1, 4096);
        put_reg(7, 1);
        put_reg(0, 10);
        @(negedge clk); wr_en = 1; wr_reg = 3'd0; wr_lane = 2'd2; wr_data = 8'h00;
        @(negedge clk); wr_lane = 2'd1; wr_data = 8'h01;
        @(negedge clk); wr_en = 0;
        put_mode(8'h64);
        tick(2);
        r0 = rises;
        put_cmd(8'h10);
        chk("R4 remaining loaded", remaining, 10);
        wait_idle(500);
        tick(3);
        chk("R1 pulse count uses committed value", rises - r0, 10);
        chk("R4 remaining at end", remaining, 0);
        chk("R4 cause count end", stop_cause, 7'h08);
        chk("R5 position clockwise", position, 10);
        chk("R12 no irq without request", irq, 0);

        // R5 counter-clockwise and disabled position
        put_reg(0, 5);
        put_mode(8'h6C);
        tick(2);
        chk("R14 dir follows mode when idle", dir_out, 1);
        put_cmd(8'h10);
        wait_idle(500);
        tick(2);
        chk("R5 position counter-clockwise", position, 5);
        put_reg(0, 3);
        put_mode(8'h4C);
        tick(2);
        put_cmd(8'h10);
        wait_idle(500);
        tick(2);
        chk("R5 position hold when disabled", position, 5);

        // R2 fixed speed selection
        put_reg(2, 2048);
        put_reg(3, 1000);
        put_mode(8'h40);
        put_cmd(8'h11);
        chk("R2 select high A", cur_speed, 2048);
        put_cmd(8'h08);
        chk("R11 cause stop command", stop_cause, 7'h40);
        put_cmd(8'h13);
        chk("R2 select high B", cur_speed, 1000);
        put_cmd(8'h08);
        put_cmd(8'h12);
        chk("R2 select low via 10", cur_speed, 4096);
        put_cmd(8'h08);

        // R3 random rates
        for (int k = 0; k < 6; k++) begin
            int spd, mul;
            spd = 512 << ($urandom % 4);
            mul = 1 + ($urandom % 4);
            put_reg(1, spd);
            put_reg(7, mul);
            put_cmd(8'h10);
            wait_step(1, 200); t1 = cyc;
            wait_step(0, 200); t2 = cyc;
            wait_step(1, 200); t3 = cyc;
            chk("R3 step period", t3 - t1, exp_period(spd, mul));
            chk("R3 step high half", t2 - t1, exp_period(spd, mul) / 2);
            put_cmd(8'h08);
        end

        // R6 acceleration, R9 ramp-down on the way, R10 decelerating stop
        begin
            int arate;
            arate = 2 + ($urandom % 6);
            put_reg(1, 1024);
            put_reg(2, 1040);
            put_reg(4, arate);
            put_reg(5, 3);
            put_reg(7, 1);
            put_cmd(8'h15);
            chk("R6 starts at low", cur_speed, 1024);
            watch_speed(16 * arate + 40, intv, mx, mn);
            chk("R6 accel interval", intv, arate);
            chk("R6 clamp at high", mx, 1040);
            chk("R6 holds high", cur_speed, 1040);
            put_cmd(8'h14);
            watch_speed(80, intv, mx, mn);
            chk("R9 decel interval", intv, 3);
            chk("R9 reaches low", cur_speed, 1024);
            chk("R9 keeps running", busy, 1);
            put_cmd(8'h15);
            watch_speed(16 * arate + 40, intv, mx, mn);
            chk("R6 retarget up", cur_speed, 1040);
            put_cmd(8'h1F);
            wait_idle(300);
            tick(1);
            chk("R10 stop speed low", cur_speed, 1024);
            chk("R10 cause decel stop", stop_cause, 7'h10);
            put_cmd(8'h10);
            tick(4);
            chk("R10 start ignored while locked", busy, 0);
            put_cmd(8'h08);
            put_cmd(8'h10);
            chk("R10 start after release", busy, 1);
            put_cmd(8'h08);
        end

        // R7 programmed ramp-down point
        put_reg(2, 1100);
        put_reg(4, 2);
        put_reg(5, 2);
        put_reg(0, 200);
        put_reg(6, 40);
        put_mode(8'h44);
        ramp_move(1100, rem_at, accp, pulses);
        tick(1);
        chk("R7 drop not before point", (rem_at <= 40) ? 1 : 0, 1);
        chk("R7 drop at point", (rem_at >= 38) ? 1 : 0, 1);
        chk("R7 pulse total", pulses, 200);
        chk("R7 ends at low", cur_speed, 1024);

        // R8 automatic ramp-down point, programmed point far away
        put_reg(6, 150);
        put_mode(8'h54);
        ramp_move(1100, rem_at, accp, pulses);
        tick(1);
        chk("R8 drop near accel pulses", (rem_at <= accp + 1 && rem_at >= accp - 2) ? 1 : 0, 1);
        if (!(rem_at <= accp + 1 && rem_at >= accp - 2))
            $display("  R8 detail rem_at=%0d accel_pulses=%0d", rem_at, accp);
        chk("R8 pulse total", pulses, 200);

        // R12 / R11 interrupt
        put_reg(1, 4096);
        put_reg(0, 4);
        put_cmd(8'h30);
        wait_idle(200);
        tick(1);
        chk("R12 irq at end", irq, 1);
        put_cmd(8'h08);
        chk("R11 0x08 clears irq", irq, 0);
        put_cmd(8'h28);
        chk("R11 0x28 sets irq", irq, 1);
        put_cmd(8'h08);

        // R13 limits and alarm
        put_mode(8'h40);
        tick(2);
        put_cmd(8'h10);
        @(negedge clk); lim_neg = 1;
        tick(4);
        chk("R13 opposite limit ignored", busy, 1);
        lim_neg = 0; lim_pos = 1;
        tick(2);
        chk("R13 positive limit stops", busy, 0);
        chk("R13 positive cause", stop_cause, 7'h02);
        lim_pos = 0;
        put_mode(8'h48);
        tick(2);
        put_cmd(8'h10);
        @(negedge clk); lim_neg = 1; lim_pos = 1;
        tick(2);
        chk("R13 negative cause", stop_cause, 7'h01);
        lim_neg = 0; lim_pos = 0;
        put_cmd(8'h10);
        @(negedge clk); alarm_in = 1;
        tick(2);
        chk("R13 alarm cause", stop_cause, 7'h20);
        alarm_in = 0;
        tick(2);
        chk("R14 direction held during moves", dir_viol, 0);

        done = 1;
        $display("[TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end
endmodule